// File: doc/BRIEF.md
# Bridge Window Control Register Bank

This block holds the configuration registers of a host-to-PCI bridge. There are a number of address windows. Each window has a base register, a mask register and a translated-base register. The bank also holds one 64-bit bridge control register. A separate translation unit reads the window settings through flat export buses, and the control register is exported the same way.

The bank also decodes a small set of status and maintenance registers that follow fixed rules. Two of them read as zero and quietly take writes. One reads as zero but rejects writes. Any other offset, and any offset the bank does not implement, gets an error response.

Software reaches the bank through a 64-bit access port with a request channel and a response channel. Both use valid/ready. The bank has one response slot. A request is accepted only while that slot is empty, or while it is being drained in the same cycle. A response stays on the pins, unchanged, until `rsp_ready` is high at a clock edge.

Top module: `brg_csr_bank`

## Requirements
- R1: After reset, every window base, mask and translated-base register is zero. The control register holds 64'h0000_0021_0010_0000, which means bits 20, 32 and 37 are set. `rsp_valid` is low and `req_ready` is high.
- R2: The register index is `req_addr[11:6]`, so registers sit 64 bytes apart. Offset bits 5:0 do not affect which register is selected.
- R3: With 4 windows, index w selects window base w (indices 0-3), index 4+w selects window mask w, and index 8+w selects translated base w. All of them are fully readable and writable, and a register changes only when it is written.
- R4: Index 12 is the control register. It is fully readable and writable, and it changes only when it is written.
- R5: Index 16 is the error-status register. It reads as zero. A write to it completes without error and changes nothing.
- R6: Index 17 is the error-mask register. A read returns zero without error. A write returns an error response.
- R7: Index 18 is the invalidate-all register. It reads as zero. A write to it completes without error and changes no register.
- R8: Any other index returns an error response, for both reads and writes. An access that errors changes no register, and every error response carries zero data.
- R9: A request is accepted at a clock edge where `req_valid` and `req_ready` are both high. The response is valid from the next cycle. While `rsp_valid` is high and `rsp_ready` is low, the response and its data are held and `req_ready` is low.
- R10: A write takes effect at the edge that accepts it, and the export buses show the new value from the next cycle. Write responses carry zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Bank can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset inside the 4 KB region |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_error | output | 1 | Access was rejected |
| rsp_rdata | output | 64 | Read data (zero for writes and errors) |
| win_base_o | output | 256 | Window base registers, window 0 in the low 64 bits |
| win_mask_o | output | 256 | Window mask registers, window 0 in the low 64 bits |
| xlat_base_o | output | 256 | Translated-base registers, window 0 in the low 64 bits |
| ctrl_o | output | 64 | Bridge control register |

## Verification
The bench builds the bank with its default parameters: four windows, 64-bit registers and a 12-bit offset with a 64-byte stride. With these values, the whole index space of 64 entries can be reached with random offsets. The same run covers every register group, the fixed-rule registers at indices 16 to 18, and the undefined indices above and between them. Random response stalls of zero to three cycles exercise the hold and back-pressure behaviour, and non-zero low offset bits exercise the stride decode.

// File: rtl/brg_csr_pkg.sv
package brg_csr_pkg;
  // Class of register selected by an index
  typedef enum logic [2:0] {
    K_WBASE,
    K_WMASK,
    K_XBASE,
    K_CTRL,
    K_ESTAT,
    K_EMASK,
    K_INVAL,
    K_BAD
  } csr_kind_e;
endpackage

// File: rtl/brg_csr_decode.sv
module brg_csr_decode
  import brg_csr_pkg::*;
#(
  parameter int NUM_WIN   = 4,
  parameter int IDX_W     = 6,
  parameter int WIN_IDX_W = 2
) (
  input  logic [IDX_W-1:0]     idx,
  output csr_kind_e            kind,
  output logic [WIN_IDX_W-1:0] win
);
  localparam int MASK_LO = NUM_WIN;
  localparam int XLAT_LO = 2 * NUM_WIN;
  localparam int CTRL_IX = 3 * NUM_WIN;
  localparam int ESTA_IX = CTRL_IX + 4;
  localparam int EMSK_IX = CTRL_IX + 5;
  localparam int INVA_IX = CTRL_IX + 6;

  always_comb begin
    kind = K_BAD;
    win  = '0;
    if (idx < IDX_W'(MASK_LO)) begin
      kind = K_WBASE;
      win  = WIN_IDX_W'(idx);
    end else if (idx < IDX_W'(XLAT_LO)) begin
      kind = K_WMASK;
      win  = WIN_IDX_W'(idx - IDX_W'(MASK_LO));
    end else if (idx < IDX_W'(CTRL_IX)) begin
      kind = K_XBASE;
      win  = WIN_IDX_W'(idx - IDX_W'(XLAT_LO));
    end else if (idx == IDX_W'(CTRL_IX)) begin
      kind = K_CTRL;
    end else if (idx == IDX_W'(ESTA_IX)) begin
      kind = K_ESTAT;
    end else if (idx == IDX_W'(EMSK_IX)) begin
      kind = K_EMASK;
    end else if (idx == IDX_W'(INVA_IX)) begin
      kind = K_INVAL;
    end
  end
endmodule

// File: rtl/brg_csr_store.sv
module brg_csr_store
  import brg_csr_pkg::*;
#(
  parameter int                NUM_WIN   = 4,
  parameter int                DATA_W    = 64,
  parameter int                WIN_IDX_W = 2,
  parameter logic [DATA_W-1:0] CTRL_RST  = '0
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  csr_kind_e                        kind,
  input  logic [WIN_IDX_W-1:0]             win,
  input  logic [DATA_W-1:0]                wdata,
  output logic [NUM_WIN-1:0][DATA_W-1:0]   base_q,
  output logic [NUM_WIN-1:0][DATA_W-1:0]   mask_q,
  output logic [NUM_WIN-1:0][DATA_W-1:0]   xlat_q,
  output logic [DATA_W-1:0]                ctrl_q,
  output logic [DATA_W-1:0]                rd_val
);
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic hit;
    assign hit = wr_en && (win == WIN_IDX_W'(w));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[w] <= '0;
        mask_q[w] <= '0;
        xlat_q[w] <= '0;
      end else if (hit) begin
        if (kind == K_WBASE) base_q[w] <= wdata;
        if (kind == K_WMASK) mask_q[w] <= wdata;
        if (kind == K_XBASE) xlat_q[w] <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                        ctrl_q <= CTRL_RST;
    else if (wr_en && kind == K_CTRL)  ctrl_q <= wdata;
  end

  // Fixed-rule registers fall to the zero default
  always_comb begin
    unique case (kind)
      K_WBASE: rd_val = base_q[win];
      K_WMASK: rd_val = mask_q[win];
      K_XBASE: rd_val = xlat_q[win];
      K_CTRL:  rd_val = ctrl_q;
      default: rd_val = '0;
    endcase
  end
endmodule

// File: rtl/brg_csr_bank.sv
module brg_csr_bank
  import brg_csr_pkg::*;
#(
  parameter int                NUM_WIN   = 4,
  parameter int                DATA_W    = 64,
  parameter int                ADDR_W    = 12,
  parameter int                STRIDE_LG = 6,
  parameter logic [DATA_W-1:0] CTRL_RST  = 64'h0000_0021_0010_0000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic                        req_write,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [DATA_W-1:0]           req_wdata,
  output logic                        rsp_valid,
  input  logic                        rsp_ready,
  output logic                        rsp_error,
  output logic [DATA_W-1:0]           rsp_rdata,
  output logic [NUM_WIN*DATA_W-1:0]   win_base_o,
  output logic [NUM_WIN*DATA_W-1:0]   win_mask_o,
  output logic [NUM_WIN*DATA_W-1:0]   xlat_base_o,
  output logic [DATA_W-1:0]           ctrl_o
);
  localparam int IDX_W     = ADDR_W - STRIDE_LG;
  localparam int WIN_IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

  csr_kind_e                      kind;
  logic [WIN_IDX_W-1:0]           win;
  logic                           fire, acc_err, wr_en;
  logic [DATA_W-1:0]              rd_val;
  logic [NUM_WIN-1:0][DATA_W-1:0] base_q, mask_q, xlat_q;
  logic                           unused_low;

  assign unused_low = ^req_addr[STRIDE_LG-1:0];

  brg_csr_decode #(
    .NUM_WIN  (NUM_WIN),
    .IDX_W    (IDX_W),
    .WIN_IDX_W(WIN_IDX_W)
  ) u_dec (
    .idx (req_addr[ADDR_W-1:STRIDE_LG]),
    .kind(kind),
    .win (win)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;
  assign acc_err   = (kind == K_BAD) || (req_write && kind == K_EMASK);
  assign wr_en     = fire && req_write && !acc_err;

  brg_csr_store #(
    .NUM_WIN  (NUM_WIN),
    .DATA_W   (DATA_W),
    .WIN_IDX_W(WIN_IDX_W),
    .CTRL_RST (CTRL_RST)
  ) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .kind  (kind),
    .win   (win),
    .wdata (req_wdata),
    .base_q(base_q),
    .mask_q(mask_q),
    .xlat_q(xlat_q),
    .ctrl_q(ctrl_o),
    .rd_val(rd_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_error <= 1'b0;
      rsp_rdata <= '0;
    end else if (fire) begin
      rsp_valid <= 1'b1;
      rsp_error <= acc_err;
      rsp_rdata <= (acc_err || req_write) ? '0 : rd_val;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign win_base_o  = base_q;
  assign win_mask_o  = mask_q;
  assign xlat_base_o = xlat_q;
endmodule

// File: rtl/brg_csr_chk.sv
module brg_csr_chk #(
  parameter int NUM_WIN = 4,
  parameter int DATA_W  = 64
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      req_valid,
  input logic                      req_ready,
  input logic                      req_write,
  input logic                      rsp_valid,
  input logic                      rsp_ready,
  input logic                      rsp_error,
  input logic [DATA_W-1:0]         rsp_rdata,
  input logic [NUM_WIN*DATA_W-1:0] win_base_o,
  input logic [NUM_WIN*DATA_W-1:0] win_mask_o,
  input logic [NUM_WIN*DATA_W-1:0] xlat_base_o,
  input logic [DATA_W-1:0]         ctrl_o
);
  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_error));
  // R9
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);
  // R9
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> req_ready);
  // R8
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_error |-> rsp_rdata == '0);
  // R4
  ctrl_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready && req_write) |=> $stable(ctrl_o));
  // R3
  win_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready && req_write) |=>
      $stable(win_base_o) && $stable(win_mask_o) && $stable(xlat_base_o));
endmodule

bind brg_csr_bank brg_csr_chk #(.NUM_WIN(NUM_WIN), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_write  (req_write),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_error  (rsp_error),
  .rsp_rdata  (rsp_rdata),
  .win_base_o (win_base_o),
  .win_mask_o (win_mask_o),
  .xlat_base_o(xlat_base_o),
  .ctrl_o     (ctrl_o)
);

// File: tb/brg_csr_bank_test.sv
module brg_csr_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] CTRL_INIT = 64'h0000_0021_0010_0000;
  // register classes used by the bench model
  localparam int C_BASE = 0, C_MASK = 1, C_XLAT = 2, C_CTRL = 3,
                 C_ESTAT = 4, C_EMASK = 5, C_INVAL = 6, C_BAD = 7;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, rsp_ready = 0;
  logic [11:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_error;
  logic [63:0] rsp_rdata, ctrl_o;
  logic [255:0] win_base_o, win_mask_o, xlat_base_o;

  int total = 0, bad = 0, cycles = 0;
  logic [63:0] m_base [4];
  logic [63:0] m_mask [4];
  logic [63:0] m_xlat [4];
  logic [63:0] m_ctrl;

  always #(CLK_PERIOD / 2) clk = ~clk;

  brg_csr_bank uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_error(rsp_error),
    .rsp_rdata(rsp_rdata), .win_base_o(win_base_o), .win_mask_o(win_mask_o),
    .xlat_base_o(xlat_base_o), .ctrl_o(ctrl_o)
  );

  function automatic int classify(input int ix);
    if (ix < 4)  return C_BASE;
    if (ix < 8)  return C_MASK;
    if (ix < 12) return C_XLAT;
    if (ix == 12) return C_CTRL;
    if (ix == 16) return C_ESTAT;
    if (ix == 17) return C_EMASK;
    if (ix == 18) return C_INVAL;
    return C_BAD;
  endfunction

  function automatic logic [63:0] model_read(input int k, input int ix);
    case (k)
      C_BASE: return m_base[ix];
      C_MASK: return m_mask[ix - 4];
      C_XLAT: return m_xlat[ix - 8];
      C_CTRL: return m_ctrl;
      default: return '0;
    endcase
  endfunction

  function automatic string tag_of(input int k);
    case (k)
      C_BASE, C_MASK, C_XLAT: return "R3";
      C_CTRL:  return "R4";
      C_ESTAT: return "R5";
      C_EMASK: return "R6";
      C_INVAL: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_exports(input string req);
    logic [255:0] eb, em, ex;
    for (int w = 0; w < 4; w++) begin
      eb[w*64 +: 64] = m_base[w];
      em[w*64 +: 64] = m_mask[w];
      ex[w*64 +: 64] = m_xlat[w];
    end
    check(win_base_o == eb, req, win_base_o, eb);
    check(win_mask_o == em, req, win_mask_o, em);
    check(xlat_base_o == ex, req, xlat_base_o, ex);
    check(ctrl_o == m_ctrl, req, ctrl_o, m_ctrl);
  endtask

  task automatic access(input bit wr, input logic [11:0] addr, input logic [63:0] wd,
                        input int stall);
    int ix, k;
    bit ee;
    logic [63:0] er;
    string t;
    ix = int'(addr[11:6]);
    k  = classify(ix);
    ee = (k == C_BAD) || (wr && k == C_EMASK);
    er = (wr || ee) ? 64'h0 : model_read(k, ix);
    t  = tag_of(k);
    @(negedge clk);
    check(req_ready == 1'b1, "R9", req_ready, 1);
    req_valid = 1; req_write = wr; req_addr = addr; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    if (wr && !ee) begin
      case (k)
        C_BASE: m_base[ix] = wd;
        C_MASK: m_mask[ix - 4] = wd;
        C_XLAT: m_xlat[ix - 8] = wd;
        C_CTRL: m_ctrl = wd;
        default: ;
      endcase
    end
    check(rsp_valid == 1'b1, "R9", rsp_valid, 1);
    check(rsp_error == ee, t, rsp_error, ee);
    check(rsp_rdata == er, wr ? "R10" : t, rsp_rdata, er);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      check(rsp_valid && !req_ready && rsp_rdata == er && rsp_error == ee, "R9",
            {rsp_valid, req_ready, rsp_error}, {1'b1, 1'b0, ee});
    end
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    check(rsp_valid == 1'b0, "R9", rsp_valid, 0);
    check_exports((ee || k == C_ESTAT || k == C_INVAL) ? t : "R10");
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int w = 0; w < 4; w++) begin
      m_base[w] = '0; m_mask[w] = '0; m_xlat[w] = '0;
    end
    m_ctrl = CTRL_INIT;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(rsp_valid == 1'b0 && req_ready == 1'b1, "R1", {rsp_valid, req_ready}, 2'b01);
    check_exports("R1");
    access(0, 12'h300, '0, 0);                        // R1/R4 control readback
    // R2 low offset bits ignored
    access(1, 12'h06A, 64'hDEAD_BEEF_0123_4567, 1);
    access(0, 12'h07F, '0, 0);
    access(1, 12'h100, 64'h1111_2222_3333_4444, 0);   // R3 mask window 0
    access(1, 12'h2C0, 64'hFFFF_0000_FFFF_0000, 2);   // R3 xlat window 3
    access(1, 12'h300, 64'h0123_4567_89AB_CDEF, 0);   // R4
    access(0, 12'h300, '0, 3);
    access(1, 12'h400, 64'hFFFF_FFFF_FFFF_FFFF, 0);   // R5 write ignored
    access(0, 12'h400, '0, 0);
    access(0, 12'h440, '0, 0);                        // R6 read zero
    access(1, 12'h440, 64'h5A5A, 1);                  // R6 write error
    access(1, 12'h480, 64'h7777, 0);                  // R7
    access(0, 12'h480, '0, 0);
    access(1, 12'h340, 64'hABCD, 0);                  // R8 reserved index 13
    access(0, 12'hFC0, '0, 2);                        // R8 index 63
    for (int i = 0; i < 300; i++) begin
      logic [11:0] a;
      a = 12'($urandom);
      if ($urandom % 4 != 0) a[11:6] = 6'($urandom % 20);
      access(1'($urandom), a, {$urandom, $urandom}, int'($urandom % 4));
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule